// File: doc/BRIEF.md
# Timing Loop Mode Sequencer with Frequency Holdover

This block decides which of three operating modes a digital timing loop is in: free running on the local oscillator, tracking a reference, or coasting on remembered frequency. While the loop tracks a good reference, each update sample of the loop's frequency control word is folded into an exponential moving average. When the reference goes away, that average becomes the frequency command. A fixed calibration word is the command when no trustworthy history exists.

Each cycle the sequencer takes the reference-good and lock indications, the live frequency word with its sample strobe, the calibration word and an optional forced mode. It registers the mode and the command word sent on toward the DAC. It also reports whether the history holds enough samples to be used.

Top module: `hoc_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `mode_o` is 0 (free run), `hist_valid` is 0 and `ctrl_word` is 0.
- R2: Mode codes are 0 = free run, 1 = synchronized, 2 = holdover. When the mode register holds 0 at a rising edge, `ctrl_word` after that edge equals `cal_word` as sampled at that edge.
- R3: With `force_en` low, from free run or holdover the mode becomes 1 at the next edge when `ref_valid` and `loop_locked` are both high.
- R4: When the mode register holds 1 at a rising edge, `ctrl_word` after that edge equals `freq_in` as sampled at that edge.
- R5: A `freq_stb` pulse in mode 1 updates the signed history. The first sample ever taken is loaded directly. Each later sample x changes the history h to h + ((x - h) >>> SHIFT), an arithmetic shift that rounds toward minus infinity.
- R6: `hist_valid` rises in the cycle after the MIN_SAMPLES-th sample accepted in mode 1. It then stays high until reset.
- R7: With `force_en` low, when mode 1 sees `ref_valid` or `loop_locked` low and `hist_valid` is high, the mode becomes 2 at the next edge. While the mode register holds 2, `ctrl_word` after each edge is the history value.
- R8: With `force_en` low, when mode 1 sees the reference or the lock lost and `hist_valid` is low, the mode becomes 0 at the next edge.
- R9: Outside mode 1, `freq_stb` pulses are ignored and the history stays frozen. This is seen in the holdover command word.
- R10: While `force_en` is high, the next mode follows `force_mode`: 1 gives mode 1, 2 gives mode 2 if `hist_valid` is high and mode 0 otherwise, and 0 or 3 gives mode 0.
- R11: `mode_o` never shows code 3, and mode 2 is never held while `hist_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Selected reference is present and good |
| loop_locked | input | 1 | Loop reports phase lock |
| freq_in | input | W | Live signed frequency control word from the loop |
| freq_stb | input | 1 | One-cycle strobe marking a new frequency sample |
| cal_word | input | W | Calibration word used in free run |
| force_en | input | 1 | Overrides automatic mode selection |
| force_mode | input | 2 | Requested mode while forced |
| mode_o | output | 2 | Current mode (0 free run, 1 synchronized, 2 holdover) |
| ctrl_word | output | W | Registered frequency command toward the DAC path |
| hist_valid | output | 1 | History holds at least MIN_SAMPLES samples |

## Verification
The bench builds the block with W = 12, SHIFT = 2 and MIN_SAMPLES = 4. With these values the history becomes usable after a handful of strobes, so both loss-of-reference outcomes, with and without history, occur in a short run. The two-bit shift gives visible rounding of negative differences. The 12-bit words let random samples reach both signs and the extremes of the range.

// File: rtl/hoc_pkg.sv
package hoc_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_SYNC = 2'd1,
    MODE_HOLD = 2'd2
  } hoc_mode_e;
endpackage

// File: rtl/hoc_history.sv
module hoc_history #(
  parameter int W           = 16,
  parameter int SHIFT       = 3,
  parameter int MIN_SAMPLES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd_en,
  input  logic signed [W-1:0] sample,
  output logic signed [W-1:0] avg_o,
  output logic                valid_o
);
  localparam int CW = $clog2(MIN_SAMPLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_SAMPLES);

  logic signed [W-1:0] avg_q;
  logic signed [W-1:0] avg_step;
  logic [CW-1:0]       cnt_q;

  generate
    if (SHIFT == 0) begin : g_track
      assign avg_step = sample;
    end else begin : g_ema
      logic signed [W:0] diff;
      logic signed [W:0] step;
      logic signed [W:0] sum;
      always_comb begin
        diff = {sample[W-1], sample} - {avg_q[W-1], avg_q};
        step = diff >>> SHIFT;
        sum  = {avg_q[W-1], avg_q} + step;
      end
      assign avg_step = sum[W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      avg_q <= '0;
      cnt_q <= '0;
    end else if (upd_en) begin
      avg_q <= (cnt_q == '0) ? sample : avg_step;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign avg_o   = avg_q;
  assign valid_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/hoc_mode_fsm.sv
module hoc_mode_fsm
  import hoc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ref_ok,
  input  logic      locked,
  input  logic      hist_ok,
  input  logic      force_en,
  input  logic [1:0] force_sel,
  output hoc_mode_e mode_q
);
  hoc_mode_e mode_d;
  logic      track_ok;

  assign track_ok = ref_ok & locked;

  always_comb begin
    mode_d = mode_q;
    if (force_en) begin
      case (force_sel)
        2'd1:    mode_d = MODE_SYNC;
        2'd2:    mode_d = hist_ok ? MODE_HOLD : MODE_FREE;
        default: mode_d = MODE_FREE;
      endcase
    end else begin
      case (mode_q)
        MODE_SYNC: if (!track_ok) mode_d = hist_ok ? MODE_HOLD : MODE_FREE;
        default:   if (track_ok)  mode_d = MODE_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_FREE;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/hoc_ctrl.sv
module hoc_ctrl
  import hoc_pkg::*;
#(
  parameter int W           = 16,
  parameter int SHIFT       = 3,
  parameter int MIN_SAMPLES = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ref_valid,
  input  logic         loop_locked,
  input  logic [W-1:0] freq_in,
  input  logic         freq_stb,
  input  logic [W-1:0] cal_word,
  input  logic         force_en,
  input  logic [1:0]   force_mode,
  output logic [1:0]   mode_o,
  output logic [W-1:0] ctrl_word,
  output logic         hist_valid
);
  hoc_mode_e           mode_q;
  logic signed [W-1:0] hist_avg;
  logic                hist_ok;
  logic [W-1:0]        ctrl_q;

  hoc_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .ref_ok    (ref_valid),
    .locked    (loop_locked),
    .hist_ok   (hist_ok),
    .force_en  (force_en),
    .force_sel (force_mode),
    .mode_q    (mode_q)
  );

  hoc_history #(
    .W           (W),
    .SHIFT       (SHIFT),
    .MIN_SAMPLES (MIN_SAMPLES)
  ) u_hist (
    .clk     (clk),
    .rst     (rst),
    .upd_en  (freq_stb && (mode_q == MODE_SYNC)),
    .sample  ($signed(freq_in)),
    .avg_o   (hist_avg),
    .valid_o (hist_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      case (mode_q)
        MODE_SYNC: ctrl_q <= freq_in;
        MODE_HOLD: ctrl_q <= hist_avg;
        default:   ctrl_q <= cal_word;
      endcase
    end
  end

  assign mode_o     = mode_q;
  assign ctrl_word  = ctrl_q;
  assign hist_valid = hist_ok;
endmodule

// File: rtl/hoc_ctrl_chk.sv
module hoc_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         ref_valid,
  input logic         loop_locked,
  input logic         force_en,
  input logic [W-1:0] cal_word,
  input logic [1:0]   mode_o,
  input logic [W-1:0] ctrl_word,
  input logic         hist_valid,
  input logic [W-1:0] hist_avg
);
  p_mode_legal_r11: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);

  p_hold_needs_hist_r11: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd2) |-> hist_valid);

  p_free_word_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_o) == 2'd0) |-> (ctrl_word == $past(cal_word)));

  p_sync_entry_r3: assert property (@(posedge clk) disable iff (rst)
    (!force_en && ref_valid && loop_locked) |=> (mode_o == 2'd1));

  p_loss_no_hist_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1 && !force_en && !(ref_valid && loop_locked) && !hist_valid)
      |=> (mode_o == 2'd0));

  p_loss_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1 && !force_en && !(ref_valid && loop_locked) && hist_valid)
      |=> (mode_o == 2'd2));

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd1) |=> $stable(hist_avg));

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    hist_valid |=> hist_valid);
endmodule

bind hoc_ctrl hoc_ctrl_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_valid   (ref_valid),
  .loop_locked (loop_locked),
  .force_en    (force_en),
  .cal_word    (cal_word),
  .mode_o      (mode_o),
  .ctrl_word   (ctrl_word),
  .hist_valid  (hist_valid),
  .hist_avg    (hist_avg)
);

// File: tb/sim_hoc_ctrl.sv
module sim_hoc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int SHIFT = 2;
  localparam int MIN_SAMPLES = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ref_valid = 1'b0;
  logic         loop_locked = 1'b0;
  logic [W-1:0] freq_in = '0;
  logic         freq_stb = 1'b0;
  logic [W-1:0] cal_word = 12'd123;
  logic         force_en = 1'b0;
  logic [1:0]   force_mode = 2'd0;
  logic [1:0]   mode_o;
  logic [W-1:0] ctrl_word;
  logic         hist_valid;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  string req = "R1";

  int m_mode = 0;
  int m_avg = 0;
  int m_cnt = 0;
  int m_ctrl = 0;

  hoc_ctrl #(.W(W), .SHIFT(SHIFT), .MIN_SAMPLES(MIN_SAMPLES)) u0 (
    .clk, .rst, .ref_valid, .loop_locked, .freq_in, .freq_stb, .cal_word,
    .force_en, .force_mode, .mode_o, .ctrl_word, .hist_valid
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model, updated from inputs that are stable at the edge
  always @(posedge clk) begin
    int  nm;
    bit  hv;
    bit  trk;
    if (rst) begin
      m_mode = 0; m_avg = 0; m_cnt = 0; m_ctrl = 0;
    end else begin
      hv  = (m_cnt >= MIN_SAMPLES);
      trk = ref_valid && loop_locked;
      if (m_mode == 1) m_ctrl = $signed(freq_in);
      else if (m_mode == 2) m_ctrl = m_avg;
      else m_ctrl = $signed(cal_word);
      nm = m_mode;
      if (force_en) begin
        if (force_mode == 2'd1) nm = 1;
        else if (force_mode == 2'd2) nm = hv ? 2 : 0;
        else nm = 0;
      end else if (m_mode == 1) begin
        if (!trk) nm = hv ? 2 : 0;
      end else if (trk) nm = 1;
      if (m_mode == 1 && freq_stb) begin
        if (m_cnt == 0) m_avg = $signed(freq_in);
        else m_avg = m_avg + ((int'($signed(freq_in)) - m_avg) >>> SHIFT);
        if (m_cnt < MIN_SAMPLES) m_cnt++;
      end
      m_mode = nm;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    checks++;
    if (int'(mode_o) != m_mode) begin
      errors++;
      $display("FAIL %s mode: got %0d expected %0d", req, mode_o, m_mode);
    end
    checks++;
    if (int'($signed(ctrl_word)) != m_ctrl) begin
      errors++;
      $display("FAIL %s ctrl_word: got %0d expected %0d", req, $signed(ctrl_word), m_ctrl);
    end
    checks++;
    if (hist_valid != (m_cnt >= MIN_SAMPLES)) begin
      errors++;
      $display("FAIL %s hist_valid: got %0b expected %0b", req, hist_valid, m_cnt >= MIN_SAMPLES);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input int n, input bit stb_each);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      freq_in  = W'($urandom_range(4095));
      freq_stb = stb_each ? 1'b1 : (($urandom_range(1)) == 1);
    end
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R2: free run drives calibration word; R9: strobes ignored here
    req = "R2";
    run(4, 1'b1);
    #1 cal_word = 12'hF80;
    req = "R9";
    run(3, 1'b1);
    // R3/R4/R5: lock and track, two samples only
    req = "R3";
    #1 ref_valid = 1'b1; loop_locked = 1'b1; freq_stb = 1'b0;
    @(negedge clk);
    req = "R4";
    run(1, 1'b0);
    #1 freq_stb = 1'b0;
    req = "R5";
    @(negedge clk);
    #1 freq_in = 12'h7FF; freq_stb = 1'b1;
    @(negedge clk);
    #1 freq_in = 12'h800; freq_stb = 1'b1;
    @(negedge clk);
    #1 freq_stb = 1'b0;
    // R8: loss without history falls back to free run
    req = "R8";
    #1 loop_locked = 1'b0;
    run(3, 1'b0);
    // R6: relock and fill the history
    req = "R6";
    #1 loop_locked = 1'b1;
    run(8, 1'b1);
    req = "R5";
    run(10, 1'b0);
    // R7: loss with history enters holdover
    req = "R7";
    #1 ref_valid = 1'b0;
    run(3, 1'b0);
    // R9: history frozen in holdover despite strobes
    req = "R9";
    run(6, 1'b1);
    // R3: holdover back to synchronized
    req = "R3";
    #1 ref_valid = 1'b1;
    run(4, 1'b1);
    // R10: forced modes
    req = "R10";
    #1 force_en = 1'b1; force_mode = 2'd2;
    run(3, 1'b1);
    #1 force_mode = 2'd3;
    run(3, 1'b0);
    #1 force_mode = 2'd1; ref_valid = 1'b0;
    run(3, 1'b1);
    #1 force_mode = 2'd0;
    run(2, 1'b0);
    #1 force_en = 1'b0;
    // R11: automatic again, reference lost from free run stays free
    req = "R11";
    run(4, 1'b0);
    // R10: forced holdover without history after reset gives free run
    req = "R1";
    #1 rst = 1'b1;
    run(2, 1'b0);
    #1 rst = 1'b0;
    @(negedge clk);
    req = "R10";
    #1 force_en = 1'b1; force_mode = 2'd2;
    run(3, 1'b0);
    #1 force_en = 1'b0;
    @(negedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule